// File: doc/BRIEF.md
# Bitstream-Steered Instruction Order Verifier

This block decides whether a block of instructions was laid out in the one order that a secret-derived bitstream dictates. The caller loads a dependency matrix for the block, the order actually observed in memory and a minimum entropy threshold, then pulses `start`. The verifier walks a list scheduler through the block, one slot at a time. At each slot the ready set holds every unplaced instruction whose predecessors are all placed. The verifier pulls just enough serial bits to index one member of that set, places that member, and compares it with the instruction observed in the slot.

The bitstream arrives one bit per cycle over a valid/ready handshake. The number of bits taken at a slot depends on how many instructions are ready there. The total number of bits taken measures the block's freedom of ordering. A block that matches but offers too little freedom is still refused. When the walk ends, `done` rises with exactly one of `run` or `abort`. These outputs stay put until the next accepted start.

Top module: `instr_order_verifier`

## Requirements
- R1: After reset, `done`, `run`, `abort`, `low_entropy` and `bit_ready` are all low, and `run`/`abort` stay low whenever `done` is low.
- R2: Instruction i is ready at a slot when it is not yet placed and every j with bit `i*N+j` of `dep_matrix` set is already placed. A fully chained block (each i depending on i-1) is therefore accepted only in ascending order and takes no bits.
- R3: A slot with k ready instructions takes exactly ceil(log2 k) bits: none for k=1, one for k=2, two for k=3..4, three for k=5..8. The first bit received is the most significant bit of the index field.
- R4: Ready instructions are numbered from 0 in ascending order of original position. An index value v of k or more selects candidate v-k.
- R5: The observed instruction for slot s sits at bits `[s*IDXW +: IDXW]` of `seen_order`. Any slot that differs from the selected instruction gives `abort`. A full match with enough entropy gives `run`.
- R6: `low_entropy` is high when the total number of bits taken is below `min_entropy`, and it then forces `abort`. A total equal to the threshold is enough.
- R7: A `start` while a walk is in progress is ignored and does not change its verdict. After `done`, the verdict outputs hold until the next start is accepted.
- R8: If the ready set is empty before all slots are filled (a cyclic or self dependency), the walk ends at once with `done` and `abort`.
- R9: A bit is taken only on a cycle where both `bit_valid` and `bit_ready` are high, so gaps in `bit_valid` only stretch the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a walk when idle; latches the three inputs below |
| dep_matrix | input | N*N | Row i, bit j set: instruction i must follow instruction j |
| seen_order | input | N*IDXW | Observed instruction index for each slot |
| min_entropy | input | EW | Minimum total of bits that must be taken |
| bit_valid | input | 1 | Serial bitstream bit is offered |
| bit_data | input | 1 | Serial bitstream bit |
| bit_ready | output | 1 | The verifier wants another bit for the current slot |
| done | output | 1 | Verdict available |
| run | output | 1 | Block accepted |
| abort | output | 1 | Block refused |
| low_entropy | output | 1 | Bits taken fell short of the threshold |

## Verification
A fully chained graph fixes the ready set size at one, so it separates correct handling of dependencies from any use of the bitstream. A graph with no dependencies drives the ready set from eight down to one and goes through every field width and every modulo fold. Pseudo-random acyclic graphs mix these cases. Each is run with the correctly ordered slots and with two slots swapped, which tells a real comparison apart from a constant verdict. Thresholds equal to and one above the bit total, cyclic graphs, gapped `bit_valid`, and a second start in mid-walk cover the edges of the entropy rule, deadlock and handshake.

// File: rtl/ivo_pkg.sv
package ivo_pkg;
  localparam int MAXN = 64;

  // bits needed to index one of k ready instructions: ceil(log2 k)
  function automatic int field_width(input int k);
    int w;
    w = 0;
    for (int b = 0; b < 7; b++)
      if ((1 << b) < k) w = b + 1;
    return w;
  endfunction

  // a field of ceil(log2 k) bits is below 2k, so one subtract folds it into 0..k-1
  function automatic int fold_index(input int v, input int k);
    return (v >= k) ? (v - k) : v;
  endfunction

  // position of the n-th set bit, counting from bit 0 upward
  function automatic int nth_set(input logic [MAXN-1:0] m, input int n);
    int seen;
    int pos;
    seen = 0;
    pos = 0;
    for (int i = 0; i < MAXN; i++)
      if (m[i]) begin
        if (seen == n) pos = i;
        seen = seen + 1;
      end
    return pos;
  endfunction

  typedef enum logic {ST_IDLE, ST_WALK} walk_state_t;
endpackage

// File: rtl/ivo_ready_set.sv
module ivo_ready_set #(
  parameter int N  = 8,
  parameter int KW = $clog2(N + 1)
) (
  input  logic [N*N-1:0] deps,
  input  logic [N-1:0]   placed,
  output logic [N-1:0]   cand,
  output logic [KW-1:0]  cand_cnt
);
  for (genvar i = 0; i < N; i++) begin : g_row
    assign cand[i] = !placed[i] && ((deps[i*N +: N] & ~placed) == '0);
  end

  always_comb begin
    cand_cnt = '0;
    for (int i = 0; i < N; i++) cand_cnt = cand_cnt + KW'(cand[i]);
  end
endmodule

// File: rtl/ivo_pick.sv
module ivo_pick import ivo_pkg::*; #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N),
  parameter int KW   = $clog2(N + 1),
  parameter int WW   = $clog2(IDXW + 1)
) (
  input  logic [N-1:0]    cand,
  input  logic [KW-1:0]   cand_cnt,
  input  logic [IDXW-1:0] field,
  output logic [WW-1:0]   width_need,
  output logic [IDXW-1:0] pick_idx
);
  int sel;
  always_comb begin
    width_need = WW'(field_width(int'(cand_cnt)));
    sel        = fold_index(int'(field), int'(cand_cnt));
    pick_idx   = IDXW'(nth_set(MAXN'(cand), sel));
  end
endmodule

// File: rtl/instr_order_verifier.sv
module instr_order_verifier import ivo_pkg::*; #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N),
  parameter int EW   = $clog2(N * $clog2(N) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N-1:0]    dep_matrix,
  input  logic [N*IDXW-1:0] seen_order,
  input  logic [EW-1:0]     min_entropy,
  input  logic              bit_valid,
  input  logic              bit_data,
  output logic              bit_ready,
  output logic              done,
  output logic              run,
  output logic              abort,
  output logic              low_entropy
);
  localparam int KW = $clog2(N + 1);
  localparam int WW = $clog2(IDXW + 1);

  walk_state_t       state;
  logic [N*N-1:0]    dep_q;
  logic [N*IDXW-1:0] obs_q;
  logic [EW-1:0]     min_q;
  logic [N-1:0]      placed;
  logic [IDXW-1:0]   slot;
  logic [IDXW-1:0]   acc;
  logic [WW-1:0]     got;
  logic [EW-1:0]     ent;
  logic              mism;

  logic [N-1:0]      cand;
  logic [KW-1:0]     cand_cnt;
  logic [WW-1:0]     width_need;
  logic [IDXW-1:0]   pick_idx;

  // named internal events
  logic              walking, bit_take, place_evt, stall_evt, last_slot, slot_bad;
  logic [IDXW-1:0]   obs_here;
  logic [EW-1:0]     ent_next;
  logic              mism_next, low_next;

  ivo_ready_set #(.N(N), .KW(KW)) u_ready (
    .deps(dep_q), .placed(placed), .cand(cand), .cand_cnt(cand_cnt)
  );

  ivo_pick #(.N(N), .IDXW(IDXW), .KW(KW), .WW(WW)) u_pick (
    .cand(cand), .cand_cnt(cand_cnt), .field(acc),
    .width_need(width_need), .pick_idx(pick_idx)
  );

  assign walking   = (state == ST_WALK);
  assign bit_ready = walking && (cand_cnt != '0) && (got < width_need);
  assign bit_take  = bit_valid && bit_ready;
  assign place_evt = walking && (cand_cnt != '0) && (got == width_need);
  assign stall_evt = walking && (cand_cnt == '0);
  assign last_slot = (slot == IDXW'(N - 1));
  assign obs_here  = obs_q[slot*IDXW +: IDXW];
  assign slot_bad  = (pick_idx != obs_here);
  assign ent_next  = ent + EW'(width_need);
  assign mism_next = mism || slot_bad;
  assign low_next  = (ent_next < min_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      dep_q       <= '0;
      obs_q       <= '0;
      min_q       <= '0;
      placed      <= '0;
      slot        <= '0;
      acc         <= '0;
      got         <= '0;
      ent         <= '0;
      mism        <= 1'b0;
      done        <= 1'b0;
      run         <= 1'b0;
      abort       <= 1'b0;
      low_entropy <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state       <= ST_WALK;
        dep_q       <= dep_matrix;
        obs_q       <= seen_order;
        min_q       <= min_entropy;
        placed      <= '0;
        slot        <= '0;
        acc         <= '0;
        got         <= '0;
        ent         <= '0;
        mism        <= 1'b0;
        done        <= 1'b0;
        run         <= 1'b0;
        abort       <= 1'b0;
        low_entropy <= 1'b0;
      end
    end else begin
      if (stall_evt) begin
        state       <= ST_IDLE;
        done        <= 1'b1;
        run         <= 1'b0;
        abort       <= 1'b1;
        low_entropy <= (ent < min_q);
      end else if (bit_take) begin
        acc <= IDXW'({acc, bit_data});
        got <= got + WW'(1);
      end else if (place_evt) begin
        placed[pick_idx] <= 1'b1;
        ent  <= ent_next;
        mism <= mism_next;
        acc  <= '0;
        got  <= '0;
        slot <= slot + IDXW'(1);
        if (last_slot) begin
          state       <= ST_IDLE;
          done        <= 1'b1;
          low_entropy <= low_next;
          run         <= !mism_next && !low_next;
          abort       <= mism_next || low_next;
        end
      end
    end
  end

  // R1
  quiet_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!run && !abort));
  // R3
  bits_need_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_take |-> (cand_cnt > KW'(1)));
  // R4
  pick_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    place_evt |-> cand[pick_idx]);
  // R5
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run != abort));
  // R6
  low_forces_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_entropy |-> (abort && !run));
  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(run) && $stable(low_entropy)));
  // R8
  stall_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> (done && abort));
  // R9
  bit_only_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && !bit_valid && !place_evt && !stall_evt) |=> $stable(got));
endmodule

// File: tb/sim_instr_order_verifier.sv
module sim_instr_order_verifier;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int EW    = 5;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N-1:0]  dep_matrix = '0;
  logic [N*IW-1:0] seen_order = '0;
  logic [EW-1:0]   min_entropy = '0;
  logic bit_valid, bit_data, bit_ready, done, run, abort, low_entropy;

  logic [63:0] stream = '0;
  int   ptr = 0;
  logic ptr_clr = 1'b0;
  logic feed_en = 1'b0;
  logic gap_mode = 1'b0;
  logic gap_tick = 1'b0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_P/2) clk = ~clk;

  assign bit_data  = stream[ptr % 64];
  assign bit_valid = feed_en && (!gap_mode || gap_tick);

  always @(posedge clk) begin
    gap_tick <= ~gap_tick;
    cyc <= cyc + 1;
    if (ptr_clr) ptr <= 0;
    else if (bit_valid && bit_ready) ptr <= ptr + 1;
  end

  instr_order_verifier #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dep_matrix(dep_matrix),
    .seen_order(seen_order), .min_entropy(min_entropy), .bit_valid(bit_valid),
    .bit_data(bit_data), .bit_ready(bit_ready), .done(done), .run(run),
    .abort(abort), .low_entropy(low_entropy)
  );

  always @(posedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // independent scheduler model
  int          m_used;
  bit          m_dead;
  logic [N*IW-1:0] m_ord;
  task automatic model(input logic [N*N-1:0] dep, input logic [63:0] strm);
    bit [N-1:0] done_set;
    done_set = '0;
    m_used = 0;
    m_dead = 0;
    m_ord = '0;
    for (int s = 0; s < N; s++) begin
      int ready[N];
      int k;
      int w;
      int v;
      k = 0;
      for (int i = 0; i < N; i++) begin
        bit ok;
        ok = !done_set[i];
        for (int j = 0; j < N; j++) if (dep[i*N+j] && !done_set[j]) ok = 0;
        if (ok) begin ready[k] = i; k++; end
      end
      if (k == 0) begin m_dead = 1; return; end
      w = 0;
      while ((1 << w) < k) w++;
      v = 0;
      for (int b = 0; b < w; b++) begin
        v = v * 2 + int'(strm[m_used]);
        m_used++;
      end
      v = v % k;
      done_set[ready[v]] = 1;
      m_ord[s*IW +: IW] = IW'(ready[v]);
    end
  endtask

  task automatic launch(input logic [N*N-1:0] dep, input logic [63:0] strm,
                        input logic [N*IW-1:0] obs, input int minent);
    @(negedge clk);
    dep_matrix = dep; seen_order = obs; min_entropy = EW'(minent);
    stream = strm; feed_en = 1'b1; start = 1'b1; ptr_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; ptr_clr = 1'b0;
  endtask

  task automatic await_done(input string req);
    int n;
    n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check(done == 1'b1, req, int'(done), 1);
  endtask

  task automatic verdict(input logic [N*IW-1:0] obs, input int minent, input string req);
    bit exp_low, exp_run;
    exp_low = (m_used < minent);
    exp_run = !m_dead && (obs == m_ord) && !exp_low;
    check(run == exp_run, req, int'(run), int'(exp_run));
    check(abort == !exp_run, req, int'(abort), int'(!exp_run));
    check(low_entropy == exp_low, "R6", int'(low_entropy), int'(exp_low));
    check(ptr == m_used, "R3", ptr, m_used);
  endtask

  task automatic full_case(input logic [N*N-1:0] dep, input logic [63:0] strm,
                           input bit corrupt, input int thr_add, input string req);
    logic [N*IW-1:0] obs;
    int thr;
    model(dep, strm);
    obs = m_ord;
    if (corrupt) begin
      obs[0 +: IW] = m_ord[(N-1)*IW +: IW];
      obs[(N-1)*IW +: IW] = m_ord[0 +: IW];
    end
    thr = m_used + thr_add;
    if (thr < 0) thr = 0;
    launch(dep, strm, obs, thr);
    await_done(req);
    verdict(obs, thr, req);
  endtask

  function automatic logic [N*N-1:0] chain_graph();
    logic [N*N-1:0] d;
    d = '0;
    for (int i = 1; i < N; i++) d[i*N + i - 1] = 1'b1;
    return d;
  endfunction

  function automatic logic [N*N-1:0] rand_graph(input logic [63:0] r, input int sparse);
    logic [N*N-1:0] d;
    d = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < i; j++)
        d[i*N+j] = ((r[(i*7 + j*3) % 64 +: 1] == 1'b1) && (((i + j + sparse) % 3) == 0));
    return d;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 0, "R1", int'(done), 0);
    check(run == 0 && abort == 0, "R1", int'({run, abort}), 0);
    check(low_entropy == 0, "R1", int'(low_entropy), 0);
    check(bit_ready == 0, "R1", int'(bit_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_ready == 0 && done == 0, "R1", int'({bit_ready, done}), 0);

    // R2: full chain, identity order, no bits
    full_case(chain_graph(), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R2");
    check(m_used == 0, "R2", m_used, 0);
    full_case(chain_graph(), 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R5");
    // R6: zero-entropy block below threshold 1
    full_case(chain_graph(), 64'h0, 0, 1, "R6");

    // R3 R4: no dependencies, widths 3,3,3,3,2,2,1,0
    for (int t = 0; t < 8; t++) begin
      logic [63:0] s;
      s = (t == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : (t == 1) ? 64'h0 : next_rand();
      full_case('0, s, 0, 0, "R4");
      check(m_used == 17, "R3", m_used, 17);
      full_case('0, s, 1, 0, "R5");
    end
    // R6 boundary: threshold equal passes, one above fails
    full_case('0, next_rand(), 0, 0, "R6");
    full_case('0, next_rand(), 0, 1, "R6");

    // R2 R5: pseudo-random acyclic graphs
    for (int t = 0; t < 24; t++) begin
      logic [N*N-1:0] g;
      logic [63:0] s;
      g = rand_graph(next_rand(), t);
      s = next_rand();
      full_case(g, s, 0, 0, "R2");
      full_case(g, s, 1, 0, "R5");
      full_case(g, s, 0, (t % 2), "R6");
    end

    // R9: gapped bit_valid
    gap_mode = 1'b1;
    for (int t = 0; t < 6; t++) full_case(rand_graph(next_rand(), t), next_rand(), t % 2, 0, "R9");
    gap_mode = 1'b0;

    // R8: cycle between 0 and 1, and a self dependency on 3
    begin
      logic [N*N-1:0] g;
      g = '0; g[0*N+1] = 1'b1; g[1*N+0] = 1'b1;
      full_case(g, next_rand(), 0, 0, "R8");
      check(m_dead == 1, "R8", int'(m_dead), 1);
      g = '0; g[3*N+3] = 1'b1;
      full_case(g, next_rand(), 0, 0, "R8");
    end

    // R7: start while busy is ignored, verdict then holds
    begin
      logic [63:0] s;
      bit r0, l0;
      s = next_rand();
      model('0, s);
      launch('0, s, m_ord, m_used);
      @(negedge clk);
      dep_matrix = chain_graph(); seen_order = '0; min_entropy = EW'(31);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      await_done("R7");
      verdict(m_ord, m_used, "R7");
      r0 = run; l0 = low_entropy;
      repeat (6) @(negedge clk);
      check(done == 1 && run == r0 && low_entropy == l0, "R7",
            int'({done, run, low_entropy}), int'({1'b1, r0, l0}));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule